// File: doc/BRIEF.md
# Round-Robin Task Context Switcher

This unit swaps the running task for the next one whenever a switch strobe arrives from the non-maskable interrupt path. It copies the interrupted task's register snapshot, one 16-bit word per cycle, into that task's record in an external single-port RAM. It then steps the task index to the next task and reads that task's record back. The restored register set is presented on a wide bus together with a one-cycle valid pulse.

The block is built to recover from corrupted state without outside help. The task index is exactly log2(NTASK) bits wide, so every value it can hold names a real task. The code segment handed back is always the new task's entry from a fixed, ROM-style limit table. The instruction pointer handed back is rounded down to a 16-byte boundary. Whatever garbage sits in a record, the restore therefore produces a legal segment and an aligned entry point.

The strobe and the snapshot are control-side inputs. There is no back-pressure anywhere. The snapshot must be stable in the cycle the strobe is sampled. The consumer of the restore bus must take the data in the one cycle that the valid pulse is high.

Top module: `ctx_switch_engine`

## Requirements
- R1: The task index is log2(NTASK) bits wide and resets to 0. Each accepted switch raises it by one, and task NTASK-1 is followed by task 0.
- R2: After an accepted strobe, the engine makes 13 consecutive RAM writes, one per cycle. The write at slot k goes to word address TBASE + 13*index + k, using the index before it advances. The words follow the fixed slot order: flags, code segment, instruction pointer, ax, ds, bx, cx, dx, si, di, es, fs, gs.
- R3: After the saves, the engine reads the 13 words of the new index's record, one per cycle, from the same address layout. RAM read data arrives one cycle after the request. Every restored word other than slot 1 and slot 2 equals the stored word bit for bit.
- R4: Restored slot 1 (code segment) is the limit-table entry for the new task. When the stored value already matches that entry, the output equals the stored value.
- R5: Restored slot 2 (instruction pointer) equals the stored value with its low four bits cleared.
- R6: `restore_valid` is high for exactly one cycle. It rises 27 cycles after the clock edge that samples the strobe. No RAM access takes place in that cycle.
- R7: A strobe sampled while a switch is in progress is ignored. It causes no extra restore and no extra index step.
- R8: While reset is applied and directly after it, there is no RAM access and no restore pulse, and the index reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Switch strobe; sampled only when the engine is idle |
| snap_regs | input | 208 | Interrupted task's registers; slot k in bits [16k+15:16k] |
| cur_task | output | log2(NTASK) | Current task index |
| restore_valid | output | 1 | One-cycle pulse marking `restore_regs` as valid |
| restore_regs | output | 208 | Sanitised register set of the new task, same slot layout |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable (read when low) |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after a read request |
| cslim_idx | output | log2(NTASK) | Task index into the code-segment limit table |
| cslim_data | input | 16 | Limit-table entry for `cslim_idx`, combinational |

## Verification
Call the edge that samples a strobe e0. The thirteen save writes fall on the edges after e0. The reads follow on the next thirteen edges, and the restore pulse is visible in the cycle after e27, 28 cycles after the strobe was driven. The driver stamps each expected restore with the cycle counter value at which it drove the strobe. The monitor samples on the falling edge and compares each pulse against the record at the head of the queue, checking the 28-cycle latency, the task index and every word. The saved records are read from the bench's RAM model only after a switch has finished. A strobe injected in the middle of a switch pushes nothing into the queue, so any extra pulse it caused would surface as an unexpected restore.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  localparam int REC_WORDS = 13;
  localparam int WORD_W    = 16;
  localparam int REC_W     = REC_WORDS * WORD_W;
  localparam int SLOT_W    = $clog2(REC_WORDS);
  localparam int SLOT_CS   = 1;
  localparam int SLOT_IP   = 2;
  localparam logic [WORD_W-1:0] IP_KEEP = 16'hFFF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_LOAD,
    ST_WAIT,
    ST_OUT
  } sw_state_t;
endpackage

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int NTASK = 4,
  localparam int IDXW = $clog2(NTASK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  output sw_state_t         state,
  output logic [SLOT_W-1:0] slot,
  output logic [IDXW-1:0]   idx
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(REC_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          slot <= '0;
          if (req) state <= ST_SAVE;
        end
        ST_SAVE: begin
          if (slot == LAST_SLOT) begin
            slot  <= '0;
            idx   <= IDXW'(idx + 1'b1);
            state <= ST_LOAD;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_LOAD: begin
          if (slot == LAST_SLOT) begin
            slot  <= '0;
            state <= ST_WAIT;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_WAIT: state <= ST_OUT;
        ST_OUT:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: index only ever moves by a single modular step
  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> (idx == IDXW'($past(idx) + 1'b1)));
endmodule

// File: rtl/ctxsw_recbuf.sv
module ctxsw_recbuf
  import ctxsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_snap,
  input  logic [REC_W-1:0]  snap_in,
  input  logic              rd_issue,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] wr_word,
  output logic [REC_W-1:0]  rec_out
);
  logic [WORD_W-1:0] snap_q [REC_WORDS];
  logic [WORD_W-1:0] rec_q  [REC_WORDS];
  logic              rd_vld;
  logic [SLOT_W-1:0] rd_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_slot <= '0;
    end else begin
      rd_vld  <= rd_issue;
      rd_slot <= slot;
    end
  end

  for (genvar k = 0; k < REC_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (cap_snap) snap_q[k] <= snap_in[k*WORD_W +: WORD_W];
      if (rd_vld && rd_slot == SLOT_W'(k)) rec_q[k] <= rd_data;
    end
    assign rec_out[k*WORD_W +: WORD_W] = rec_q[k];
  end

  assign wr_word = snap_q[slot];
endmodule

// File: rtl/ctxsw_sanitize.sv
module ctxsw_sanitize
  import ctxsw_pkg::*;
(
  input  logic [REC_W-1:0]  rec_in,
  input  logic [WORD_W-1:0] cs_fixed,
  output logic [REC_W-1:0]  rec_out
);
  for (genvar k = 0; k < REC_WORDS; k++) begin : g_fix
    logic [WORD_W-1:0] w;
    assign w = rec_in[k*WORD_W +: WORD_W];
    if (k == SLOT_CS) begin : g_cs
      assign rec_out[k*WORD_W +: WORD_W] = (w == cs_fixed) ? w : cs_fixed;
    end else if (k == SLOT_IP) begin : g_ip
      assign rec_out[k*WORD_W +: WORD_W] = w & IP_KEEP;
    end else begin : g_pass
      assign rec_out[k*WORD_W +: WORD_W] = w;
    end
  end
endmodule

// File: rtl/ctx_switch_engine.sv
module ctx_switch_engine
  import ctxsw_pkg::*;
#(
  parameter int NTASK  = 4,
  parameter int ADDR_W = 10,
  parameter int TBASE  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_req,
  input  logic [REC_W-1:0]           snap_regs,
  output logic [$clog2(NTASK)-1:0]   cur_task,
  output logic                       restore_valid,
  output logic [REC_W-1:0]           restore_regs,
  output logic                       ram_en,
  output logic                       ram_we,
  output logic [ADDR_W-1:0]          ram_addr,
  output logic [WORD_W-1:0]          ram_wdata,
  input  logic [WORD_W-1:0]          ram_rdata,
  output logic [$clog2(NTASK)-1:0]   cslim_idx,
  input  logic [WORD_W-1:0]          cslim_data
);
  localparam int IDXW = $clog2(NTASK);

  sw_state_t         state;
  logic [SLOT_W-1:0] slot;
  logic [IDXW-1:0]   idx;
  logic [ADDR_W-1:0] rec_base;
  logic [REC_W-1:0]  rec_raw;
  logic              cap_snap;

  ctxsw_seq #(.NTASK(NTASK)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (sw_req),
    .state (state),
    .slot  (slot),
    .idx   (idx)
  );

  assign cap_snap = (state == ST_IDLE) && sw_req;

  ctxsw_recbuf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_snap (cap_snap),
    .snap_in  (snap_regs),
    .rd_issue (state == ST_LOAD),
    .slot     (slot),
    .rd_data  (ram_rdata),
    .wr_word  (ram_wdata),
    .rec_out  (rec_raw)
  );

  ctxsw_sanitize u_fix (
    .rec_in   (rec_raw),
    .cs_fixed (cslim_data),
    .rec_out  (restore_regs)
  );

  assign rec_base      = ADDR_W'(TBASE + int'(idx) * REC_WORDS);
  assign ram_addr      = rec_base + ADDR_W'(slot);
  assign ram_en        = (state == ST_SAVE) || (state == ST_LOAD);
  assign ram_we        = (state == ST_SAVE);
  assign restore_valid = (state == ST_OUT);
  assign cur_task      = idx;
  assign cslim_idx     = idx;

  // R2: every save lands inside the current task's record
  assert_wr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |->
      (ram_addr >= rec_base && ram_addr < rec_base + ADDR_W'(REC_WORDS)));

  // R3: every read falls in the record of the index after the step
  assert_rd_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |->
      (ram_addr >= rec_base && ram_addr < rec_base + ADDR_W'(REC_WORDS)));

  // R6: valid is a single-cycle pulse
  assert_onepulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !restore_valid);

  // R6: RAM stays idle while the result is presented
  assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> !ram_en);

  // R7: a strobe during a switch does not restart the save
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> !(ram_en && ram_we));
endmodule

// File: tb/ctx_switch_engine_test.sv
module ctx_switch_engine_test;
  import ctxsw_pkg::*;
  localparam int NT = 4;
  localparam int AW = 10;
  localparam int TB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 1'b0;
  logic [REC_W-1:0] snap_regs = '0;
  logic [1:0] cur_task, cslim_idx;
  logic restore_valid, ram_en, ram_we;
  logic [REC_W-1:0] restore_regs;
  logic [AW-1:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata, cslim_data;

  always #4 clk = ~clk;

  ctx_switch_engine #(.NTASK(NT), .ADDR_W(AW), .TBASE(TB)) uut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .snap_regs(snap_regs),
    .cur_task(cur_task), .restore_valid(restore_valid),
    .restore_regs(restore_regs), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .cslim_idx(cslim_idx), .cslim_data(cslim_data));

  logic [15:0] mem [1024];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  function automatic logic [15:0] lim_cs(int t);
    return 16'h1000 + 16'(t * 256);
  endfunction
  assign cslim_data = lim_cs(int'(cslim_idx));

  int errors = 0;
  int checks = 0;
  longint cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] shadow [NT][REC_WORDS];
  int cur = 0;
  logic [REC_W-1:0] q_bus [$];
  int q_tid [$];
  longint q_cyc [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [REC_W-1:0] mk_snap(int n, int t);
    logic [REC_W-1:0] s;
    for (int w = 0; w < REC_WORDS; w++) s[w*16 +: 16] = 16'hA000 + 16'(n * 256 + w);
    if (n % 2 == 0) begin
      s[SLOT_CS*16 +: 16] = lim_cs(t);
      s[SLOT_IP*16 +: 16] = 16'h2340 + 16'(n * 16);
    end
    return s;
  endfunction

  task automatic do_switch(int n, int inject_busy);
    logic [REC_W-1:0] s, e;
    int saved;
    saved = cur;
    s = mk_snap(n, cur);
    @(negedge clk);
    snap_regs = s;
    sw_req = 1'b1;
    for (int w = 0; w < REC_WORDS; w++) shadow[cur][w] = s[w*16 +: 16];
    cur = (cur + 1) % NT;
    for (int w = 0; w < REC_WORDS; w++) e[w*16 +: 16] = shadow[cur][w];
    e[SLOT_CS*16 +: 16] = lim_cs(cur);
    e[SLOT_IP*16 +: 16] = shadow[cur][SLOT_IP] & 16'hFFF0;
    q_bus.push_back(e);
    q_tid.push_back(cur);
    q_cyc.push_back(cyc);
    @(negedge clk);
    sw_req = 1'b0;
    snap_regs = '1;
    if (inject_busy != 0) begin
      repeat (inject_busy) @(negedge clk);
      sw_req = 1'b1;   // R7: strobe mid-switch, no expectation pushed
      @(negedge clk);
      sw_req = 1'b0;
    end
    repeat (32) @(negedge clk);
    for (int w = 0; w < REC_WORDS; w++)
      check("R2 saved word", 32'(mem[TB + saved * REC_WORDS + w]), 32'(s[w*16 +: 16]));
    check("R1 index after switch", 32'(cur_task), 32'(cur));
  endtask

  always @(negedge clk) begin
    if (rst_n && restore_valid) begin
      if (q_bus.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected restore actual=1 expected=0");
      end else begin
        logic [REC_W-1:0] e;
        int t;
        longint c;
        e = q_bus.pop_front(); t = q_tid.pop_front(); c = q_cyc.pop_front();
        check("R6 latency", 32'(cyc - c), 32'd28);
        check("R1 restored task", 32'(cur_task), 32'(t));
        check("R4 code segment", 32'(restore_regs[SLOT_CS*16 +: 16]), 32'(e[SLOT_CS*16 +: 16]));
        check("R5 instruction pointer", 32'(restore_regs[SLOT_IP*16 +: 16]), 32'(e[SLOT_IP*16 +: 16]));
        for (int w = 0; w < REC_WORDS; w++)
          if (w != SLOT_CS && w != SLOT_IP)
            check("R3 restored word", 32'(restore_regs[w*16 +: 16]), 32'(e[w*16 +: 16]));
      end
    end
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 16'h0;
    for (int t = 0; t < NT; t++) begin
      for (int w = 0; w < REC_WORDS; w++) shadow[t][w] = 16'h0100 * 16'(t) + 16'(w * 17) + 16'h5;
      shadow[t][SLOT_CS] = (t % 2 == 1) ? 16'hDEAD : lim_cs(t);
      shadow[t][SLOT_IP] = (t % 2 == 1) ? 16'h7777 : 16'h3330;
      for (int w = 0; w < REC_WORDS; w++) mem[TB + t * REC_WORDS + w] = shadow[t][w];
    end
    repeat (3) @(negedge clk);
    check("R8 no RAM access in reset", 32'(ram_en), 32'd0);
    check("R8 no pulse in reset", 32'(restore_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 index after reset", 32'(cur_task), 32'd0);
    check("R8 idle RAM", 32'(ram_en), 32'd0);
    for (int n = 1; n <= 7; n++) do_switch(n, (n == 3) ? 6 : (n == 5 ? 20 : 0));
    check("R7 no leftover restores", 32'(q_bus.size()), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule